// File: doc/BRIEF.md
# Eight-Slot Sprite Pixel Serializer

This block keeps the pattern bits of up to eight sprites that appear on the current line. It produces one sprite pixel for every drawn position of the beam. During the sprite fetch window of the previous line, a fetch sequencer puts each slot's descriptor on the load port: tile byte, row offset, attribute bits and X position. The block turns the descriptor into the two pattern-memory addresses, one per bit plane. The same cycle, it takes in the two pattern bytes that memory returns.

Every slot has an X down-counter. The counter holds the slot silent until the beam reaches the sprite. The slot's two plane shift registers then release one bit per drawn pixel. A fixed-priority picker chooses among the opaque slots and reports the colour index, palette, behind-background flag and object-zero marker of the winner. Mixing with the background is left to a later stage.

Top module: `sprite_line_serializer`

## Requirements
- R1: While reset is asserted and after it, every slot is empty, and the pixel outputs (`px_color`, `px_palette`, `px_behind`, `px_obj0`) are all zero.
- R2: When `ld_valid` is high at a clock edge, the slot named by `ld_slot` captures `ld_x`, `ld_attr`, `ld_obj0` and the two pattern bytes. Other slots keep their state. A load takes precedence over `pix_en` for that slot.
- R3: A slot whose counter is non-zero shows a transparent pixel (colour 0) and decrements the counter on each edge where `pix_en` is high. With `pix_en` low and no load, no slot changes.
- R4: A slot whose counter is zero shows colour `{hi[7], lo[7]}`. On each edge where `pix_en` is high it shifts both planes left and fills with zero. A sprite loaded with X = x is therefore visible on drawn pixels x to x+7 (counting from 0 after the load) and transparent after them.
- R5: In 8-line mode (`ctl_tall` = 0), the low-plane address is `ctl_sprite_tbl`·4096 + tile·16 + r, where r is the 3-bit row (`ld_row[3]` is ignored). The high-plane address is 8 more.
- R6: In 16-line mode (`ctl_tall` = 1), the low-plane address is tile[0]·4096 + (tile & 0xFE)·16 + r[3]·16 + r[2:0], and `ctl_sprite_tbl` is ignored. The high-plane address is 8 more.
- R7: Attribute bit 4 (vertical flip) replaces the row with 7−row in 8-line mode and with 15−row in 16-line mode before the address is formed.
- R8: Attribute bit 3 (horizontal flip) bit-reverses both pattern bytes as they are loaded, so the leftmost pixel comes from bit 0 of the fetched byte.
- R9: A load with `ld_present` = 0 stores all-zero pattern bytes and a clear object-zero marker, whatever the pattern inputs carry, so the slot stays transparent.
- R10: Among slots with a non-zero colour, the lowest-numbered slot wins. `px_palette` is its attribute bits [1:0] and `px_behind` is its attribute bit 2. When no slot is opaque, all pixel outputs are zero.
- R11: `px_obj0` is high exactly when an opaque pixel is shown and the winning slot was loaded with `ld_obj0` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_sprite_tbl | input | 1 | Pattern half select for 8-line sprites |
| ctl_tall | input | 1 | 1 selects 16-line sprites |
| ld_valid | input | 1 | Load the slot named by ld_slot this cycle |
| ld_slot | input | 3 | Slot index to load |
| ld_present | input | 1 | Slot holds a real sprite |
| ld_obj0 | input | 1 | Sprite is object zero |
| ld_tile | input | 8 | Tile byte |
| ld_row | input | 4 | Row offset inside the sprite |
| ld_attr | input | 5 | {vflip, hflip, behind, palette[1:0]} |
| ld_x | input | 8 | Horizontal start position |
| ld_pat_lo | input | 8 | Fetched low-plane byte |
| ld_pat_hi | input | 8 | Fetched high-plane byte |
| fetch_addr_lo | output | 13 | Low-plane pattern address for the current descriptor |
| fetch_addr_hi | output | 13 | High-plane pattern address for the current descriptor |
| pix_en | input | 1 | A pixel is drawn this cycle |
| px_color | output | 2 | Winning colour index, 0 when transparent |
| px_palette | output | 2 | Winning palette select |
| px_behind | output | 1 | Winning behind-background flag |
| px_obj0 | output | 1 | Winning pixel belongs to object zero |

## Verification
On every cycle the assertions check several properties. Slots hold still when nothing is drawn or loaded. Counters step down by one and drained planes shift by one. An empty load clears the pattern. The high-plane address sits 8 above the low one, and in tall mode it follows the tile's low bit. Slot 0 always wins when it is opaque, and a transparent output never carries the object-zero marker. Some behaviour only the bench's scenarios can show: the exact pixel at which each sprite appears, its eight-pixel extent, the flips, the full address arithmetic, and priority among overlapping higher-numbered slots. The bench compares these against a model of each slot, over directed corner cases (X = 0, X = 255, fully overlapping sprites) and random lines.

// File: rtl/spr_pkg.sv
package spr_pkg;

  localparam int PAT_W  = 8;
  localparam int ATTR_W = 5;
  localparam int ADDR_W = 13;

  typedef struct packed {
    logic       vflip;
    logic       hflip;
    logic       behind;
    logic [1:0] pal;
  } spr_attr_t;

  // Row inside the sprite after optional vertical flip.
  function automatic logic [3:0] eff_row(input logic tall, input logic vflip,
                                         input logic [3:0] row);
    logic [3:0] r;
    r = tall ? row : {1'b0, row[2:0]};
    if (vflip) r = tall ? (4'd15 - r) : (4'd7 - r);
    return r;
  endfunction

  // Pattern-memory address for one plane.
  function automatic logic [ADDR_W-1:0] pat_addr(input logic tall, input logic tbl,
                                                 input logic [7:0] tile,
                                                 input logic [3:0] row,
                                                 input logic vflip, input logic plane);
    logic [3:0] r;
    r = eff_row(tall, vflip, row);
    if (tall) return {tile[0], tile[7:1], r[3], plane, r[2:0]};
    else      return {tbl, tile, plane, r[2:0]};
  endfunction

endpackage

// File: rtl/spr_addr.sv
module spr_addr
  import spr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tall,
  input  logic              tbl,
  input  logic [7:0]        tile,
  input  logic [3:0]        row,
  input  logic              vflip,
  output logic [ADDR_W-1:0] addr_lo,
  output logic [ADDR_W-1:0] addr_hi
);

  assign addr_lo = pat_addr(tall, tbl, tile, row, vflip, 1'b0);
  assign addr_hi = pat_addr(tall, tbl, tile, row, vflip, 1'b1);

  // R5 / R6: planes are eight bytes apart in either mode
  p_plane_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hi == addr_lo + ADDR_W'(8));

  // R6: in tall mode the table half follows the tile's low bit
  p_tall_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tall |-> (addr_lo[ADDR_W-1] == tile[0]));

endmodule

// File: rtl/spr_slot.sv
module spr_slot
  import spr_pkg::*;
#(
  parameter int X_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              present,
  input  logic              obj0_in,
  input  logic [X_W-1:0]    x_in,
  input  logic [ATTR_W-1:0] attr_in,
  input  logic [PAT_W-1:0]  pat_lo_in,
  input  logic [PAT_W-1:0]  pat_hi_in,
  input  logic              pix_en,
  output logic [1:0]        color,
  output logic [2:0]        attr_out,
  output logic              obj0_out,
  output logic              active
);

  logic [X_W-1:0]    cnt_q;
  logic [PAT_W-1:0]  lo_q, hi_q;
  logic [ATTR_W-1:0] attr_q;
  logic              obj0_q;
  logic [PAT_W-1:0]  lo_rev, hi_rev, lo_ld, hi_ld;
  spr_attr_t         a_in;

  assign a_in = spr_attr_t'(attr_in);

  for (genvar b = 0; b < PAT_W; b++) begin : g_rev
    assign lo_rev[b] = pat_lo_in[PAT_W-1-b];
    assign hi_rev[b] = pat_hi_in[PAT_W-1-b];
  end

  assign lo_ld = a_in.hflip ? lo_rev : pat_lo_in;
  assign hi_ld = a_in.hflip ? hi_rev : pat_hi_in;

  // event wire: the slot has reached its start position
  assign active = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      attr_q <= '0;
      obj0_q <= 1'b0;
    end else if (load) begin
      if (present) begin
        cnt_q  <= x_in;
        lo_q   <= lo_ld;
        hi_q   <= hi_ld;
        attr_q <= attr_in;
        obj0_q <= obj0_in;
      end else begin
        cnt_q  <= '0;
        lo_q   <= '0;
        hi_q   <= '0;
        attr_q <= '0;
        obj0_q <= 1'b0;
      end
    end else if (pix_en) begin
      if (!active) begin
        cnt_q <= cnt_q - X_W'(1);
      end else begin
        lo_q <= {lo_q[PAT_W-2:0], 1'b0};
        hi_q <= {hi_q[PAT_W-2:0], 1'b0};
      end
    end
  end

  assign color    = active ? {hi_q[PAT_W-1], lo_q[PAT_W-1]} : 2'b00;
  assign attr_out = attr_q[2:0];
  assign obj0_out = obj0_q;

  // R3: nothing moves without a drawn pixel or a load
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !pix_en) |=> ($stable(cnt_q) && $stable(lo_q) && $stable(hi_q)));

  // R3: a waiting slot steps its counter by exactly one and keeps its pattern
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && pix_en && !active) |=> (cnt_q == $past(cnt_q) - X_W'(1)) && $stable(lo_q));

  // R4: a running slot drains one bit per pixel
  p_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && pix_en && active) |=> (lo_q == {$past(lo_q[PAT_W-2:0]), 1'b0}) && active);

  // R9: an empty load leaves a transparent slot
  p_empty_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !present) |=> (lo_q == '0 && hi_q == '0 && !obj0_q));

  // R2: attributes only change on a load
  p_attr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(attr_q));

endmodule

// File: rtl/spr_pick.sv
module spr_pick #(
  parameter int N = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0][1:0] col,
  input  logic [N-1:0][2:0] attr,
  input  logic [N-1:0]     obj0,
  output logic [1:0]       out_col,
  output logic [1:0]       out_pal,
  output logic             out_behind,
  output logic             out_obj0
);

  always_comb begin
    out_col    = 2'b00;
    out_pal    = 2'b00;
    out_behind = 1'b0;
    out_obj0   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (col[i] != 2'b00) begin
        out_col    = col[i];
        out_pal    = attr[i][1:0];
        out_behind = attr[i][2];
        out_obj0   = obj0[i];
      end
    end
  end

  // R10: slot 0 wins whenever it is opaque
  p_slot0_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (col[0] != 2'b00) |-> (out_col == col[0] && out_pal == attr[0][1:0]));

  // R10: output is opaque only if some slot is opaque
  p_opaque_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_col != 2'b00) |-> (col != '0));

  // R11: a transparent pixel never carries the object-zero marker
  p_obj0_needs_pixel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_col == 2'b00) |-> !out_obj0);

endmodule

// File: rtl/sprite_line_serializer.sv
module sprite_line_serializer
  import spr_pkg::*;
#(
  parameter int  N_SLOTS = 8,
  parameter int  X_W     = 8,
  localparam int SLOT_W  = $clog2(N_SLOTS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_sprite_tbl,
  input  logic              ctl_tall,
  input  logic              ld_valid,
  input  logic [SLOT_W-1:0] ld_slot,
  input  logic              ld_present,
  input  logic              ld_obj0,
  input  logic [7:0]        ld_tile,
  input  logic [3:0]        ld_row,
  input  logic [ATTR_W-1:0] ld_attr,
  input  logic [X_W-1:0]    ld_x,
  input  logic [PAT_W-1:0]  ld_pat_lo,
  input  logic [PAT_W-1:0]  ld_pat_hi,
  output logic [ADDR_W-1:0] fetch_addr_lo,
  output logic [ADDR_W-1:0] fetch_addr_hi,
  input  logic              pix_en,
  output logic [1:0]        px_color,
  output logic [1:0]        px_palette,
  output logic              px_behind,
  output logic              px_obj0
);

  spr_attr_t ld_a;
  assign ld_a = spr_attr_t'(ld_attr);

  // per-slot named event wires for the checks
  logic [N_SLOTS-1:0]      slot_load;
  logic [N_SLOTS-1:0]      slot_active;
  logic [N_SLOTS-1:0][1:0] slot_col;
  logic [N_SLOTS-1:0][2:0] slot_attr;
  logic [N_SLOTS-1:0]      slot_obj0;

  spr_addr u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .tall    (ctl_tall),
    .tbl     (ctl_sprite_tbl),
    .tile    (ld_tile),
    .row     (ld_row),
    .vflip   (ld_a.vflip),
    .addr_lo (fetch_addr_lo),
    .addr_hi (fetch_addr_hi)
  );

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    assign slot_load[s] = ld_valid && (ld_slot == SLOT_W'(s));

    spr_slot #(.X_W(X_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (slot_load[s]),
      .present   (ld_present),
      .obj0_in   (ld_obj0),
      .x_in      (ld_x),
      .attr_in   (ld_attr),
      .pat_lo_in (ld_pat_lo),
      .pat_hi_in (ld_pat_hi),
      .pix_en    (pix_en),
      .color     (slot_col[s]),
      .attr_out  (slot_attr[s]),
      .obj0_out  (slot_obj0[s]),
      .active    (slot_active[s])
    );
  end

  spr_pick #(.N(N_SLOTS)) u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .col        (slot_col),
    .attr       (slot_attr),
    .obj0       (slot_obj0),
    .out_col    (px_color),
    .out_pal    (px_palette),
    .out_behind (px_behind),
    .out_obj0   (px_obj0)
  );

  // R2: at most one slot is addressed by a load
  p_one_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_load));

  // R3: a waiting slot contributes no colour
  p_wait_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((~slot_active & {N_SLOTS{1'b1}}) != '0 && slot_active == '0) |-> (px_color == 2'b00));

  // R1: the cycle after reset everything is transparent
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (px_color == 2'b00 && !px_obj0));

endmodule

// File: tb/sprite_line_serializer_test.sv
`timescale 1ns/1ps
module sprite_line_serializer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_sprite_tbl = 1'b0, ctl_tall = 1'b0;
  logic        ld_valid = 1'b0, ld_present = 1'b0, ld_obj0 = 1'b0;
  logic [2:0]  ld_slot = '0;
  logic [7:0]  ld_tile = '0, ld_x = '0, ld_pat_lo = '0, ld_pat_hi = '0;
  logic [3:0]  ld_row = '0;
  logic [4:0]  ld_attr = '0;
  logic [12:0] fetch_addr_lo, fetch_addr_hi;
  logic        pix_en = 1'b0;
  logic [1:0]  px_color, px_palette;
  logic        px_behind, px_obj0;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of the slots
  int       m_cnt [8];
  bit [7:0] m_lo [8], m_hi [8];
  bit [4:0] m_attr [8];
  bit       m_obj0 [8];

  always #2.5 clk = ~clk;

  sprite_line_serializer uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [7:0] mirror(bit [7:0] b);
    bit [7:0] r = 0;
    for (int i = 0; i < 8; i++) if (b[i]) r = r | (8'h80 >> i);
    return r;
  endfunction

  function automatic int exp_addr(bit tall, bit tbl, int tile, int row, bit vf, int plane);
    int r;
    r = tall ? row : (row % 8);
    if (vf) r = tall ? 15 - r : 7 - r;
    if (tall) return (tile % 2) * 4096 + (tile - tile % 2) * 16 + (r / 8) * 16 + plane * 8 + r % 8;
    return tbl * 4096 + tile * 16 + plane * 8 + r;
  endfunction

  // {color, palette, behind, obj0}
  function automatic bit [5:0] exp_pix();
    for (int s = 0; s < 8; s++) begin
      if (m_cnt[s] == 0 && (m_lo[s][7] || m_hi[s][7]))
        return {m_hi[s][7], m_lo[s][7], m_attr[s][1:0], m_attr[s][2], m_obj0[s]};
    end
    return 6'd0;
  endfunction

  task automatic load(int slot, bit pres, bit o0, int tile, int row, bit [4:0] attr,
                      int x, bit [7:0] lo, bit [7:0] hi);
    ld_valid = 1; ld_slot = 3'(slot); ld_present = pres; ld_obj0 = o0;
    ld_tile = 8'(tile); ld_row = 4'(row); ld_attr = attr; ld_x = 8'(x);
    ld_pat_lo = lo; ld_pat_hi = hi;
    #3;
    chk(ctl_tall ? "R6 R7 lo" : "R5 R7 lo", 32'(fetch_addr_lo),
        32'(exp_addr(ctl_tall, ctl_sprite_tbl, tile, row, attr[4], 0)));
    chk(ctl_tall ? "R6 R7 hi" : "R5 R7 hi", 32'(fetch_addr_hi),
        32'(exp_addr(ctl_tall, ctl_sprite_tbl, tile, row, attr[4], 1)));
    @(posedge clk); #1;
    ld_valid = 0;
    m_cnt[slot] = pres ? x : 0;
    m_lo[slot] = pres ? (attr[3] ? mirror(lo) : lo) : 8'h00;
    m_hi[slot] = pres ? (attr[3] ? mirror(hi) : hi) : 8'h00;
    m_attr[slot] = pres ? attr : 5'd0;
    m_obj0[slot] = pres ? o0 : 1'b0;
  endtask

  task automatic step(bit en, string tag);
    pix_en = en;
    #3;
    chk(tag, 32'({px_color, px_palette, px_behind, px_obj0}), 32'(exp_pix()));
    @(posedge clk); #1;
    if (en) begin
      for (int s = 0; s < 8; s++) begin
        if (m_cnt[s] != 0) m_cnt[s]--;
        else begin m_lo[s] = m_lo[s] << 1; m_hi[s] = m_hi[s] << 1; end
      end
    end
    pix_en = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    for (int s = 0; s < 8; s++) begin m_cnt[s]=0; m_lo[s]=0; m_hi[s]=0; m_attr[s]=0; m_obj0[s]=0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs clear during reset
    chk("R1 in reset", 32'({px_color, px_palette, px_behind, px_obj0}), 0);
    rst_n = 1;
    @(posedge clk); #1;
    step(1, "R1 after reset");

    // directed: X = 0 in slot 0, X = 2 in slot 3, others empty with junk bytes (R9)
    for (int s = 0; s < 8; s++)
      load(s, (s == 0 || s == 3), (s == 0), s * 9, s, (s == 3) ? 5'b01101 : 5'b00010,
           (s == 3) ? 2 : 0, 8'hF0 ^ 8'(s), 8'h3C);
    for (int p = 0; p < 14; p++) step(1, "R2 R4 R8 R9 R10 R11 directed");

    // directed: two slots at the same X, lower one wins (R10), obj0 on slot 1 (R11)
    for (int s = 0; s < 8; s++) load(s, 0, 0, 0, 0, 5'd0, 0, 8'hFF, 8'hFF);
    load(1, 1, 1, 5, 3, 5'b00001, 4, 8'hAA, 8'h55);
    load(2, 1, 0, 6, 3, 5'b00110, 4, 8'hFF, 8'hFF);
    step(0, "R3 idle hold");
    step(0, "R3 idle hold");
    for (int p = 0; p < 14; p++) step(1, "R10 R11 overlap");

    // directed: X = 255 appears only at the last position
    load(5, 1, 0, 1, 1, 5'b00011, 255, 8'h81, 8'h00);
    for (int p = 0; p < 266; p++) step(1, "R3 R4 far right");

    // random lines
    for (int line = 0; line < 24; line++) begin
      ctl_tall = 1'($urandom);
      ctl_sprite_tbl = 1'($urandom);
      for (int s = 0; s < 8; s++)
        load(s, ($urandom % 4) != 0, (s == 0) && 1'($urandom), int'($urandom % 256),
             int'($urandom % 16), 5'($urandom), (line % 3 == 0) ? int'($urandom % 16) : int'($urandom % 256),
             8'($urandom), 8'($urandom));
      for (int p = 0; p < 270; p++)
        step(($urandom % 10) != 0, "R2 R3 R4 R8 R9 R10 R11 random");
    end

    summary();
  end

endmodule